// File: doc/BRIEF.md
# Bit-Serial Toggle Step Counter

This block holds an N-bit value and adds or subtracts one without any carry chain or adder. After a start request, it changes the value by inverting one bit per clock. It begins at bit 0 and moves up. An increment stops on the step that turns a 0 into a 1. A decrement stops on the step that turns a 1 into a 0. The number of cycles therefore depends on the data: one step per trailing bit that gets inverted, plus one step for the bit that ends the operation.

A parallel load port sets the value while the engine is idle. The operation select is sampled with the start pulse. Two flags report progress: busy stays high for every stepping cycle, and done marks the first idle cycle afterwards. If no terminating bit appears before the top bit, the value wraps around and a wrap flag reports it. All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and never applies back-pressure. A request made while busy is dropped, not queued.

Top module: `toggle_step_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `value`, `busy`, `done` and `wrap` are all cleared to zero after that edge.
- R2: With `busy` low, `load_en` high at an edge writes `load_val` into `value` and clears `wrap`. `busy` stays low.
- R3: With `busy` low, `start` high and `load_en` low at an edge makes `busy` high after that edge and clears `wrap`. `value` does not change on that edge.
- R4: Each edge taken while `busy` is high inverts exactly one bit of `value`. The first such edge inverts bit 0, and each later edge inverts the next higher bit. Example: incrementing 0x0F shows 0x0F, 0x0E, 0x0C, 0x08, 0x00 during the busy cycles and then 0x10.
- R5: An increment (`op_dec`=0 at start) leaves `value`+1. It keeps `busy` high for k+1 cycles, where k is the number of trailing ones.
- R6: A decrement (`op_dec`=1 at start) leaves `value`-1. It keeps `busy` high for k+1 cycles, where k is the number of trailing zeros.
- R7: Incrementing all ones, or decrementing all zeros, takes N busy cycles and ends at all zeros or all ones respectively, with `wrap` set. `wrap` then holds until the next accepted start or load. An operation that does not wrap leaves `wrap` low.
- R8: `done` is high for exactly one cycle: the first cycle after the final step, when `busy` is already low and `value` holds the result.
- R9: While `busy` is high, `start`, `op_dec` and `load_en` have no effect on `value` or on the operation in progress.
- R10: If `load_en` and `start` are both high in the same idle cycle, the load is performed and the start is dropped, so `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Parallel load request, honoured only when idle |
| load_val | input | N | Value written on a load |
| start | input | 1 | Start an increment or decrement, honoured only when idle |
| op_dec | input | 1 | Operation select sampled at start: 0 increment, 1 decrement |
| value | output | N | Current register value |
| busy | output | 1 | High during every stepping cycle |
| done | output | 1 | One-cycle pulse after the final step |
| wrap | output | 1 | Last operation wrapped around; held until next start or load |

## Verification
Two sets of requests can arrive in the same cycle. The first is a load together with a start while the block is idle. The bench raises both pins on one edge and expects the loaded value to appear with `busy` still low, which means the start was dropped. The second is a new load and start arriving mid-operation. The bench injects them on a busy cycle and judges the result by the final value, the stepping count and the absence of any effect from the injected value.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic {
    OP_INC = 1'b0,
    OP_DEC = 1'b1
  } step_op_e;
endpackage

// File: rtl/tsc_index_ctr.sv
// Position of the bit handled by the next step.
module tsc_index_ctr #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          advance,
  output logic [IW-1:0] idx,
  output logic          at_top
);
  localparam logic [IW-1:0] TOP = IW'(N - 1);

  always_ff @(posedge clk) begin
    if (rst || clear)  idx <= '0;
    else if (advance)  idx <= idx + 1'b1;
  end

  assign at_top = (idx == TOP);
endmodule

// File: rtl/tsc_flip_reg.sv
// Value register: whole-word load, or inversion of one selected bit.
module tsc_flip_reg #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_go,
  input  logic [N-1:0]  load_val,
  input  logic          flip_en,
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  q,
  output logic          cur_bit
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic sel;
    assign sel = flip_en && (idx == IW'(i));
    always_ff @(posedge clk) begin
      if (rst)          q[i] <= 1'b0;
      else if (load_go) q[i] <= load_val[i];
      else if (sel)     q[i] <= ~q[i];
    end
  end

  assign cur_bit = q[idx];
endmodule

// File: rtl/tsc_seq.sv
// Request acceptance, stop decision and the status flags.
module tsc_seq
  import tsc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic load_en,
  input  logic op_in,
  input  logic cur_bit,
  input  logic at_top,
  output logic busy,
  output logic done,
  output logic wrap,
  output logic flip_en,
  output logic idx_clear,
  output logic idx_adv,
  output logic load_go
);
  step_op_e op_q;
  logic     accept, term, stop;

  assign load_go   = !busy && load_en;
  assign accept    = !busy && start && !load_en;
  assign term      = (op_q == OP_INC) ? !cur_bit : cur_bit;
  assign stop      = busy && (term || at_top);
  assign flip_en   = busy;
  assign idx_adv   = busy && !stop;
  assign idx_clear = accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      wrap <= 1'b0;
      op_q <= OP_INC;
    end else begin
      done <= stop;
      if (accept) begin
        busy <= 1'b1;
        op_q <= step_op_e'(op_in);
      end else if (stop) begin
        busy <= 1'b0;
      end
      if (accept || load_go) wrap <= 1'b0;
      else if (stop)         wrap <= !term;
    end
  end
endmodule

// File: rtl/toggle_step_counter.sv
module toggle_step_counter #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [N-1:0] load_val,
  input  logic         start,
  input  logic         op_dec,
  output logic [N-1:0] value,
  output logic         busy,
  output logic         done,
  output logic         wrap
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] idx;
  logic at_top, cur_bit, flip_en, idx_clear, idx_adv, load_go;

  tsc_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .load_en(load_en), .op_in(op_dec),
    .cur_bit(cur_bit), .at_top(at_top), .busy(busy), .done(done), .wrap(wrap),
    .flip_en(flip_en), .idx_clear(idx_clear), .idx_adv(idx_adv), .load_go(load_go)
  );

  tsc_index_ctr #(.N(N)) u_idx (
    .clk(clk), .rst(rst), .clear(idx_clear), .advance(idx_adv),
    .idx(idx), .at_top(at_top)
  );

  tsc_flip_reg #(.N(N)) u_reg (
    .clk(clk), .rst(rst), .load_go(load_go), .load_val(load_val),
    .flip_en(flip_en), .idx(idx), .q(value), .cur_bit(cur_bit)
  );
endmodule

// File: rtl/toggle_step_counter_chk.sv
module toggle_step_counter_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         load_en,
  input logic         start,
  input logic [N-1:0] value,
  input logic         busy,
  input logic         done,
  input logic         wrap
);
  // R4: every busy cycle inverts exactly one bit
  a_r4_one_bit_per_step: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($countones(value ^ $past(value)) == 1));

  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: done appears only once stepping has ended
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R3: an idle cycle without a load leaves the value as it was
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load_en) |=> $stable(value));

  // R7: a wrapped operation ends at all zeros or all ones
  a_r7_wrap_value: assert property (@(posedge clk) disable iff (rst)
    (done && wrap) |-> (value == '0 || value == '1));

  // R10: a start alongside a load does not begin an operation
  a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
    (!busy && load_en) |=> !busy);
endmodule

bind toggle_step_counter toggle_step_counter_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .load_en(load_en), .start(start),
  .value(value), .busy(busy), .done(done), .wrap(wrap)
);

// File: tb/toggle_step_counter_bench.sv
`timescale 1ns/1ps
module toggle_step_counter_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_en = 1'b0;
  logic [N-1:0] load_val = '0;
  logic         start = 1'b0;
  logic         op_dec = 1'b0;
  logic [N-1:0] value;
  logic         busy, done, wrap;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  toggle_step_counter #(.N(N)) u_toggle_step_counter (
    .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
    .start(start), .op_dec(op_dec), .value(value), .busy(busy),
    .done(done), .wrap(wrap)
  );

  task automatic expect_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_load(logic [N-1:0] v);
    @(negedge clk);
    load_en = 1'b1; load_val = v;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  // Step count and wrap predicted from the requirements.
  function automatic int steps_for(logic [N-1:0] v, bit dec);
    for (int i = 0; i < N; i++)
      if (v[i] == dec) return i + 1;
    return N;
  endfunction

  // Starts at the current negedge, counts busy cycles and checks the finish.
  task automatic run_and_check(string req, logic [N-1:0] v, bit dec, bit inject);
    logic [N-1:0] exp_v;
    int exp_c, cnt;
    bit exp_w;
    exp_v = dec ? v - 1'b1 : v + 1'b1;
    exp_c = steps_for(v, dec);
    exp_w = dec ? (v == '0) : (v == '1);
    start = 1'b1; op_dec = dec;
    @(negedge clk);
    start = 1'b0;
    expect_eq("R3", "busy after start", busy, 1);
    expect_eq("R3", "value unchanged at accept", value, v);
    cnt = 1;
    if (inject) begin  // R9: load and opposite start while busy
      load_en = 1'b1; load_val = ~v; start = 1'b1; op_dec = ~dec;
    end
    for (int g = 0; g < N + 4; g++) begin
      @(negedge clk);
      load_en = 1'b0; start = 1'b0;
      if (!busy) break;
      cnt++;
    end
    expect_eq(req, "result", value, exp_v);
    expect_eq(req, "busy cycles", cnt, exp_c);
    expect_eq("R7", "wrap", wrap, exp_w);
    expect_eq("R8", "done at finish", done, 1);
    @(negedge clk);
    expect_eq("R8", "done after one cycle", done, 0);
    expect_eq("R7", "wrap held", wrap, exp_w);
  endtask

  task automatic test_reset;
    expect_eq("R1", "value", value, 0);
    expect_eq("R1", "busy", busy, 0);
    expect_eq("R1", "done", done, 0);
    expect_eq("R1", "wrap", wrap, 0);
  endtask

  task automatic test_load;
    do_load(8'h5A);
    expect_eq("R2", "loaded value", value, 8'h5A);
    expect_eq("R2", "busy stays low", busy, 0);
  endtask

  task automatic test_sequence;
    logic [N-1:0] seq [5] = '{8'h0F, 8'h0E, 8'h0C, 8'h08, 8'h00};
    do_load(8'h0F);
    start = 1'b1; op_dec = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      expect_eq("R4", "intermediate value", value, seq[i]);
      expect_eq("R4", "busy during step", busy, 1);
      @(negedge clk);
    end
    expect_eq("R4", "final value", value, 8'h10);
    expect_eq("R8", "done at finish", done, 1);
    @(negedge clk);
  endtask

  task automatic test_inc;
    logic [N-1:0] pats [4] = '{8'h00, 8'h2B, 8'h7F, 8'hA7};
    foreach (pats[i]) begin
      do_load(pats[i]);
      run_and_check("R5", pats[i], 1'b0, 1'b0);
    end
  endtask

  task automatic test_dec;
    logic [N-1:0] pats [4] = '{8'h01, 8'h40, 8'h80, 8'hFF};
    foreach (pats[i]) begin
      do_load(pats[i]);
      run_and_check("R6", pats[i], 1'b1, 1'b0);
    end
  endtask

  task automatic test_wrap;
    do_load(8'hFF);
    run_and_check("R7", 8'hFF, 1'b0, 1'b0);
    do_load(8'h33);
    expect_eq("R7", "wrap cleared by load", wrap, 0);
    do_load(8'h00);
    run_and_check("R7", 8'h00, 1'b1, 1'b0);
    // a following non-wrapping start clears wrap
    run_and_check("R7", 8'hFF, 1'b1, 1'b0);
  endtask

  task automatic test_ignore_busy;
    do_load(8'h17);
    run_and_check("R9", 8'h17, 1'b0, 1'b1);
    do_load(8'h60);
    run_and_check("R9", 8'h60, 1'b1, 1'b1);
  endtask

  task automatic test_collision;
    @(negedge clk);
    load_en = 1'b1; load_val = 8'hC3; start = 1'b1; op_dec = 1'b0;
    @(negedge clk);
    load_en = 1'b0; start = 1'b0;
    expect_eq("R10", "loaded value", value, 8'hC3);
    expect_eq("R10", "start dropped", busy, 0);
    @(negedge clk);
    expect_eq("R10", "still idle", busy, 0);
    expect_eq("R10", "value held", value, 8'hC3);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_load();
    test_sequence();
    test_inc();
    test_dec();
    test_wrap();
    test_ignore_busy();
    test_collision();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule